// File: doc/BRIEF.md
# Cascadable Serial DAC Code Loader

This block is the digital front end of a serial voltage-output converter. A host drives a three-wire stream made of a serial clock, a serial data line and an active-low select. While select is low, each rising serial clock edge shifts one data bit into a 16-bit register, most significant bit first. When select returns high, the low 12 bits of that register are copied into a 12-bit code latch, which is presented as a parallel output for the analog stage. The top four bits of a 16-bit frame therefore never reach the latch. A single device can be programmed with a 12-bit word.

The register's top bit is driven onto a serial output on falling serial clock edges. As a result, the output repeats the input stream 16 clocks later, and further devices can be chained behind this one on the same select and clock. The block is built for 8-, 10- or 12-bit resolution. The latch stays 12 bits wide in every variant, and the positions below the resolution always read as zero.

All three serial pins are sampled by two-flop synchronisers in a system clock domain. The system clock must run at least four times faster than the serial clock.

Top module: `sdac_front`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it is released, `code_o` is 0, `sdo_o` is 0 and `upd_o` is 0.
- R2: While `sel_n_i` is low, each rising edge of `sclk_i` shifts `sdi_i` into the 16-bit register MSB first. On the next rising edge of `sel_n_i`, `code_o` takes the last 12 bits shifted in, with the most recent bit in bit 0.
- R3: While `sel_n_i` is high, edges of `sclk_i` shift nothing. A later select pulse that has no clock edges reloads `code_o` with the unchanged contents.
- R4: `code_o` changes only after a rising edge of `sel_n_i`. While a frame is being shifted in, it keeps its previous value.
- R5: While `sel_n_i` is low, `sdo_o` changes only after a falling edge of `sclk_i`. At that point it takes the bit that was shifted in 16 rising edges earlier, or 0 if fewer than 16 bits have been shifted since reset.
- R6: While `sel_n_i` is high, `sdo_o` holds its value whatever `sclk_i` does.
- R7: With `RES_BITS` set to 8 or 10, `code_o[11:12-RES_BITS]` takes the data bits and the lower `12-RES_BITS` bits of `code_o` are always 0, whatever bits were shifted into them.
- R8: A 12-bit frame with no leading bits is enough to set all 12 bits of `code_o`.
- R9: `upd_o` is high for exactly one system clock cycle for each latch load and is never high otherwise. It is high in the cycle in which the new `code_o` is first visible.
- R10: If a rising edge of `sclk_i` and a rising edge of `sel_n_i` reach the block in the same system cycle, the bit is not shifted. The latch loads the contents as they were before that clock edge.
- R11: The serial pins act on the outputs within four system clock cycles of changing, provided the serial clock's high and low phases each last at least two system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; clears latch, register and serial output |
| sclk_i | input | 1 | Serial clock, asynchronous to `clk` |
| sdi_i | input | 1 | Serial data in |
| sel_n_i | input | 1 | Select, active low; rising edge loads the latch |
| sdo_o | output | 1 | Serial data out for cascading |
| code_o | output | 12 | Latched DAC code |
| upd_o | output | 1 | One-cycle pulse when `code_o` is loaded |

## Verification
The delicate overlap is a serial clock rising edge arriving in the same synchronised cycle as the select release. In that case a shift and a latch load compete for the same register contents. The bench drives `sclk_i` and `sel_n_i` high on the same system clock edge, so both reach the edge detectors together. It then requires that the latched code equals the 12 bits held before that clock edge and that the serial output does not move. A scoreboard queue, filled when select is released and drained on each `upd_o` pulse, judges every load, including the load taken by a second instance built at 8-bit resolution.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   localparam int FRAME_W   = 16;
   localparam int CODE_W    = 12;
   localparam int SYNC_W    = 3;
   // bus order of the synchronised pins
   localparam int PIN_SDI   = 0;
   localparam int PIN_SCLK  = 1;
   localparam int PIN_SEL   = 2;
   typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
   parameter int                WIDTH   = 3,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("sdac_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d_i;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sdac_shreg.sv
module sdac_shreg
   import sdac_pkg::*;
#(
   parameter int RES_BITS = 12
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                sclk_s,
   input  logic                sdi_s,
   input  logic                sel_s,
   output logic [RES_BITS-1:0] data_o,
   output logic                sdo_o
);
   logic [FRAME_W-1:0] sr;
   logic               sclk_d;
   logic               rise, fall;

   assign rise = sclk_s & ~sclk_d;
   assign fall = ~sclk_s & sclk_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_d <= 1'b0;
         sr     <= '0;
         sdo_o  <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         if (rise && !sel_s) sr    <= {sr[FRAME_W-2:0], sdi_s};
         if (fall && !sel_s) sdo_o <= sr[FRAME_W-1];
      end
   end

   assign data_o = sr[CODE_W-1 -: RES_BITS];

   // R3
   sel_holds_reg_chk: assert property (@(posedge clk) disable iff (rst)
      sel_s |=> $stable(sr));
   // R6
   sel_holds_sdo_chk: assert property (@(posedge clk) disable iff (rst)
      sel_s |=> $stable(sdo_o));
   // R5
   rise_keeps_sdo_chk: assert property (@(posedge clk) disable iff (rst)
      rise |=> $stable(sdo_o));
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch
   import sdac_pkg::*;
#(
   parameter int RES_BITS = 12
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                sel_s,
   input  logic [RES_BITS-1:0] data_i,
   output code_t               code_o,
   output logic                upd_o
);
   localparam int PAD = CODE_W - RES_BITS;

   logic  sel_d;
   logic  load;
   code_t code_n;

   assign load = sel_s & ~sel_d;

   if (PAD == 0) begin : g_full
      assign code_n = data_i;
   end else begin : g_pad
      assign code_n = {data_i, {PAD{1'b0}}};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_d  <= 1'b1;
         code_o <= '0;
         upd_o  <= 1'b0;
      end else begin
         sel_d <= sel_s;
         upd_o <= load;
         if (load) code_o <= code_n;
      end
   end

   // R4
   code_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(code_o));
   // R9
   upd_follows_load_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> upd_o);
   // R9
   upd_single_chk: assert property (@(posedge clk) disable iff (rst)
      upd_o |=> !upd_o);

   if (PAD > 0) begin : g_pad_chk
      // R7
      pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
         code_o[PAD-1:0] == '0);
   end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
   import sdac_pkg::*;
#(
   parameter int RES_BITS    = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        sclk_i,
   input  logic        sdi_i,
   input  logic        sel_n_i,
   output logic        sdo_o,
   output logic [11:0] code_o,
   output logic        upd_o
);
   localparam logic [SYNC_W-1:0] PIN_RST = SYNC_W'(1) << PIN_SEL;

   if (RES_BITS != 8 && RES_BITS != 10 && RES_BITS != 12) begin : g_bad_res
      $error("sdac_front: RES_BITS must be 8, 10 or 12");
   end

   logic [SYNC_W-1:0]   pins_s;
   logic [RES_BITS-1:0] data;

   sdac_sync #(
      .WIDTH   (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i ({sel_n_i, sclk_i, sdi_i}),
      .q_o (pins_s)
   );

   sdac_shreg #(.RES_BITS(RES_BITS)) u_shreg (
      .clk    (clk),
      .rst    (rst),
      .sclk_s (pins_s[PIN_SCLK]),
      .sdi_s  (pins_s[PIN_SDI]),
      .sel_s  (pins_s[PIN_SEL]),
      .data_o (data),
      .sdo_o  (sdo_o)
   );

   sdac_latch #(.RES_BITS(RES_BITS)) u_latch (
      .clk    (clk),
      .rst    (rst),
      .sel_s  (pins_s[PIN_SEL]),
      .data_i (data),
      .code_o (code_o),
      .upd_o  (upd_o)
   );

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (code_o == '0 && !sdo_o && !upd_o));
endmodule

// File: tb/sdac_front_tb.sv
module sdac_front_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst, sclk, sdi, sel;
   logic sdo, upd, sdo8, upd8;
   logic [11:0] code, code8;

   int tests = 0, fails = 0;
   bit done = 1'b0;
   logic [15:0] m_sr;
   logic [11:0] prev_code;
   int q12[$], q8[$];
   logic upd_p, upd8_p;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdac_front #(.RES_BITS(12)) u_dut (
      .clk(clk), .rst(rst), .sclk_i(sclk), .sdi_i(sdi), .sel_n_i(sel),
      .sdo_o(sdo), .code_o(code), .upd_o(upd));

   sdac_front #(.RES_BITS(8)) u_dut8 (
      .clk(clk), .rst(rst), .sclk_i(sclk), .sdi_i(sdi), .sel_n_i(sel),
      .sdo_o(sdo8), .code_o(code8), .upd_o(upd8));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst) begin
         if (upd) begin
            if (q12.size() == 0) chk(0, "R9 unexpected load", int'(code), -1);
            else begin
               int e;
               e = q12.pop_front();
               chk(int'(code) == e, "R2 latched code", int'(code), e);
            end
            chk(!upd_p, "R9 pulse width", 2, 1);
         end
         if (upd8) begin
            if (q8.size() == 0) chk(0, "R9 unexpected load 8b", int'(code8), -1);
            else begin
               int e;
               e = q8.pop_front();
               chk(int'(code8) == e, "R7 8-bit code", int'(code8), e);
            end
         end
      end
      upd_p  <= upd;
      upd8_p <= upd8;
   end

   task automatic bit_out(input logic b);
      sdi = b;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      m_sr = {m_sr[14:0], b};
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      chk(sdo == m_sr[15], "R5 serial out", int'(sdo), int'(m_sr[15]));
   endtask

   task automatic release_sel();
      sel = 1'b1;
      q12.push_back(int'(m_sr[11:0]));
      q8.push_back(int'({m_sr[11:4], 4'h0}));
      prev_code = m_sr[11:0];
      repeat (8) @(negedge clk);
      chk(q12.size() == 0 && q8.size() == 0, "R9 load seen", q12.size(), 0);
   endtask

   task automatic frame(input logic [15:0] w, input int n);
      sel = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = n - 1; i >= 0; i--) bit_out(w[i]);
      // R4: no change while shifting
      chk(code == prev_code, "R4 code held", int'(code), int'(prev_code));
      release_sel();
   endtask

   initial begin
      rst = 1'b1; sclk = 1'b0; sdi = 1'b0; sel = 1'b1;
      m_sr = '0; prev_code = '0;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(code == 0 && sdo == 0 && upd == 0, "R1 reset state", int'({code, sdo, upd}), 0);

      frame(16'hA5C3, 16);
      chk(code == 12'h5C3, "R2 first frame", int'(code), 'h5C3);
      chk(code8 == 12'h5C0, "R7 pad zero", int'(code8), 'h5C0);

      // R3 / R6: clocks with select high
      begin
         logic s0;
         s0 = sdo;
         for (int k = 0; k < 3; k++) begin
            sdi = ~sdi; sclk = 1'b1; repeat (4) @(negedge clk);
            sclk = 1'b0; repeat (4) @(negedge clk);
         end
         chk(sdo == s0, "R6 sdo held", int'(sdo), int'(s0));
         sel = 1'b0; repeat (6) @(negedge clk);
         release_sel();
         chk(code == 12'h5C3, "R3 no shift while deselected", int'(code), 'h5C3);
      end

      frame(16'h0000, 12);
      frame(16'h07E1, 12);
      chk(code == 12'h7E1, "R8 twelve-bit word", int'(code), 'h7E1);
      frame(16'hFFFF, 16);
      frame(16'h1234, 16);
      chk(code == 12'h234, "R2 cascade frame", int'(code), 'h234);
      chk(code8 == 12'h230, "R7 pad zero second", int'(code8), 'h230);

      // R10: clock edge and select release together
      sel = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 11; i >= 0; i--) bit_out(((12'h0F0 >> i) & 1) != 0);
      begin
         logic s1;
         s1 = sdo;
         sdi = 1'b1; sclk = 1'b1;
         release_sel();
         chk(code == 12'h0F0, "R10 simultaneous edges", int'(code), 'h0F0);
         sclk = 1'b0; repeat (6) @(negedge clk);
         chk(sdo == s1, "R10 sdo unchanged", int'(sdo), int'(s1));
      end

      // R11: latency of a load
      sel = 1'b0; repeat (6) @(negedge clk);
      sel = 1'b1;
      q12.push_back(int'(m_sr[11:0]));
      q8.push_back(int'({m_sr[11:4], 4'h0}));
      repeat (4) @(negedge clk);
      chk(q12.size() == 0, "R11 load within four cycles", q12.size(), 0);
      repeat (4) @(negedge clk);

      // R1: reset mid-run
      rst = 1'b1; repeat (2) @(negedge clk);
      chk(code == 0 && sdo == 0, "R1 reset clears", int'({code, sdo}), 0);
      rst = 1'b0; m_sr = '0; prev_code = '0;
      @(negedge clk);
      chk(upd == 0 && code8 == 0, "R1 after release", int'({code8, upd}), 0);
      frame(16'h8001, 16);
      chk(code == 12'h001, "R2 after reset", int'(code), 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule